// File: doc/BRIEF.md
# Linked-List Receive DMA Engine

This engine moves words from an incoming valid/ready stream into a word-addressed memory. Each transfer writes at a running index that moves by a signed modifier after every word, and it stops when a word count runs out. A transfer can be programmed by hand through a small register port. It can also be described by a four-word block in the same memory. Such blocks form a list, and each block names the next one. The engine loads a block, runs that transfer, and then loads the next block. It does this until it reads a null link.

Block loads and data writes share one synchronous memory port, whose read data returns one cycle after the request. While a block is being loaded, the stream is held off. The `busy` output covers the whole list. A one-cycle `done` marks the point where the list ends.

Top module: `chain_rx_dma`

## Requirements
- R1: After reset `busy`, `done`, `s_ready` and `mem_en` are all low.
- R2: The register offsets on `cfg_addr` are: 0 = start index, 1 = modifier, 2 = word count, 3 = link pointer, 4 = control. The control bits are: bit0 = enable, bit1 = receive, bit2 = chaining. Writing control with enable and receive set while the count is nonzero starts the hand-loaded transfer on the next cycle, with `busy` and `s_ready` high.
- R3: Each accepted stream word is written at the current index. The index then moves by the modifier, modulo 2^AW, and the count drops by one.
- R4: When the count reaches zero and no further block follows, the engine goes idle. It raises `done` for exactly one cycle, with `busy` already low.
- R5: A link pointer addresses the highest word of a four-word block. The engine reads the pointer address first, then the three addresses below it. Ordered from the pointer downward, these words are the start index, the modifier, the count and the next link.
- R6: The engine may be idle with enable, receive and chaining set and a count of zero. A nonzero link-pointer write then starts a block load at once, and the stream stays held off.
- R7: With chaining set, a hand-loaded transfer runs first. A link pointer written while it runs is then used to load the next block.
- R8: A block whose next link is zero is the last one. Once its count runs out, no further read is issued and `done` fires.
- R9: Only the low AW bits (19 by default) of a written link pointer are kept.
- R10: While a block is loading, `s_ready` is low and no memory write occurs.
- R11: With the receive bit clear, nothing starts. Writes to index, modifier, count or control while `busy` is high have no effect.
- R12: `busy` stays high from the start until the final transfer ends, and `s_ready` is high only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | DW | Register write data |
| s_valid | input | 1 | Stream word valid |
| s_data | input | DW | Stream word |
| s_ready | output | 1 | Engine accepts a stream word |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |
| busy | output | 1 | Transfer or list in progress |
| done | output | 1 | One-cycle pulse at the end of the list |

## Verification
The bench checks the link pointer written with bits set above bit 18. A design that kept those bits would load a block from the wrong place and write nowhere near the expected addresses. It checks a modifier of all ones, which must wrap the index down by one; a design that failed to wrap would run the index upward. It checks the move from a hand-loaded transfer into a block load. A design that failed to hold the stream off there would write words during the load or skip the load. It also checks index writes sent during a transfer and a start attempted with the receive bit clear. A design that obeyed either would show writes at shifted addresses or a `busy` that should not exist.

// File: rtl/chain_rx_dma.sv
module chain_rx_dma #(
  parameter int DW = 32,
  parameter int AW = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  output logic          s_ready,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic          done
);
  localparam logic [2:0] A_IDX = 3'd0, A_MOD = 3'd1, A_CNT = 3'd2, A_LNK = 3'd3, A_CTL = 3'd4;
  localparam int B_EN = 0, B_RX = 1, B_CH = 2;
  localparam logic [2:0] PH_LAST = 3'd4;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_LOAD} st_t;

  st_t           st;
  logic [AW-1:0] idx, mdf, lnk;
  logic [DW-1:0] cnt;
  logic [2:0]    ctl, ph;
  logic          done_q;

  wire idle   = (st == S_IDLE);
  wire wr_ctl = cfg_we && cfg_addr == A_CTL && idle;
  wire wr_lnk = cfg_we && cfg_addr == A_LNK && st != S_LOAD;

  wire [2:0]    ctl_n = wr_ctl ? cfg_wdata[2:0] : ctl;
  wire [AW-1:0] lnk_n = wr_lnk ? cfg_wdata[AW-1:0] : lnk;
  wire          cnt_z = (cnt == '0);

  wire start  = idle && (wr_ctl || wr_lnk) && ctl_n[B_EN] && ctl_n[B_RX] &&
                (!cnt_z || (ctl_n[B_CH] && lnk_n != '0));
  wire accept = (st == S_XFER) && s_valid;
  wire [AW-1:0] nxt = mem_rdata[AW-1:0];

  assign s_ready   = (st == S_XFER);
  assign mem_we    = accept;
  assign mem_en    = accept || (st == S_LOAD && ph != PH_LAST);
  assign mem_addr  = (st == S_LOAD) ? lnk - {{(AW-3){1'b0}}, ph} : idx;
  assign mem_wdata = s_data;
  assign busy      = !idle;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; mdf <= '0; lnk <= '0; cnt <= '0;
      ctl <= '0; ph <= '0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cfg_we && idle) begin
        if (cfg_addr == A_IDX) idx <= cfg_wdata[AW-1:0];
        if (cfg_addr == A_MOD) mdf <= cfg_wdata[AW-1:0];
        if (cfg_addr == A_CNT) cnt <= cfg_wdata;
      end
      if (wr_ctl) ctl <= cfg_wdata[2:0];
      if (wr_lnk) lnk <= cfg_wdata[AW-1:0];
      case (st)
        S_IDLE: if (start) begin
          st <= cnt_z ? S_LOAD : S_XFER;
          ph <= '0;
        end
        S_XFER: if (accept) begin
          idx <= idx + mdf;
          cnt <= cnt - 1'b1;
          if (cnt == {{(DW-1){1'b0}}, 1'b1}) begin
            if (ctl[B_CH] && lnk_n != '0) begin
              st <= S_LOAD;
              ph <= '0;
            end else begin
              st <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        S_LOAD: begin
          ph <= ph + 3'd1;
          case (ph)
            3'd1: idx <= nxt;
            3'd2: mdf <= nxt;
            3'd3: cnt <= mem_rdata;
            PH_LAST: begin
              lnk <= nxt;
              ph  <= '0;
              if (!cnt_z) st <= S_XFER;
              else if (nxt == '0) begin
                st <= S_IDLE;
                done_q <= 1'b1;
              end
            end
            default: ;
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module chain_rx_dma_chk (
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic mem_en,
  input logic mem_we,
  input logic busy,
  input logic done
);
  AST_WRITE_ONLY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> s_ready); // R10
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> s_valid); // R3
  AST_READY_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n) s_ready |-> busy); // R12
  AST_IDLE_NO_MEMORY: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_en); // R12
  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R4
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> $past(busy)); // R8
endmodule

bind chain_rx_dma chain_rx_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .mem_en(mem_en), .mem_we(mem_we), .busy(busy), .done(done)
);

// File: tb/chain_rx_dma_bench.sv
`timescale 1ns/1ps
module chain_rx_dma_bench;
  localparam int  DW = 32;
  localparam int  AW = 19;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_ready, mem_en, mem_we, busy, done;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] mem [0:511];
  logic [AW+DW-1:0] expq [$];
  int n_chk = 0, n_bad = 0, n_done = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_rx_dma #(.DW(DW), .AW(AW)) u_chain_rx_dma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[8:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[8:0]];
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always begin
    @(negedge clk); #2;
    if (done) n_done++;
    if (mem_en && mem_we) begin
      if (expq.size() == 0) check(0, "R3 unexpected write", {13'd0, mem_addr, mem_wdata}, 64'd0);
      else begin
        logic [AW+DW-1:0] e;
        e = expq.pop_front();
        check({mem_addr, mem_wdata} == e, "R3 write addr/data", {13'd0, mem_addr, mem_wdata}, {13'd0, e});
      end
    end
  end

  task automatic cfg(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic send(input logic [DW-1:0] d);
    s_valid = 1'b1; s_data = d;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    expq.push_back({a, d});
  endtask

  task automatic wait_end(input string req);
    int d0 = n_done;
    for (int i = 0; i < 300 && n_done == d0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    check(n_done == d0 + 1, req, n_done - d0, 1);
    check(busy == 1'b0, req, busy, 0);
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = '0;
    mem[40] = 47; mem[41] = 3; mem[42] = 1; mem[43] = 300;
    mem[44] = 0;  mem[45] = 2; mem[46] = 32'h7FFFF; mem[47] = 400;
    repeat (3) @(negedge clk);
    check(!busy && !done && !s_ready && !mem_en, "R1 reset state", {busy, done, s_ready, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !s_ready, "R1 idle after reset", {busy, s_ready}, 0);

    // R2 R3 R4 R11: hand-loaded single transfer, index write while busy ignored
    cfg(3'd0, 100); cfg(3'd1, 1); cfg(3'd2, 3);
    expect_wr(100, 32'hA0); expect_wr(101, 32'hA1); expect_wr(102, 32'hA2);
    cfg(3'd4, 3);
    check(busy && s_ready, "R2 start on control write", {busy, s_ready}, 2'b11);
    send(32'hA0);
    cfg(3'd0, 500);
    send(32'hA1); send(32'hA2);
    wait_end("R4 single transfer end");

    // R11: receive bit clear does not start
    cfg(3'd0, 10); cfg(3'd2, 2); cfg(3'd4, 5);
    @(negedge clk);
    check(!busy, "R11 no start without receive", busy, 0);
    cfg(3'd3, 43);
    @(negedge clk);
    check(!busy, "R11 no start on link write without receive", busy, 0);

    // R7 R9 R5 R8 R10: hand-loaded then two blocks, masked pointer, wrapping modifier
    cfg(3'd0, 200); cfg(3'd1, 2); cfg(3'd2, 2);
    expect_wr(200, 32'hB0); expect_wr(202, 32'hB1);
    expect_wr(300, 32'hB2); expect_wr(301, 32'hB3); expect_wr(302, 32'hB4);
    expect_wr(400, 32'hB5); expect_wr(399, 32'hB6);
    cfg(3'd4, 7);
    cfg(3'd3, 32'h0018_002B);
    check(busy, "R12 busy during hand-loaded part", busy, 1);
    send(32'hB0); send(32'hB1);
    check(!s_ready && busy, "R10 stream held during block load", {s_ready, busy}, 2'b01);
    for (int i = 2; i < 7; i++) send(32'hB0 + i);
    wait_end("R8 list ends at null link");

    // R6: zero count, link write starts block load at once
    cfg(3'd2, 0);
    expect_wr(400, 32'hC0); expect_wr(399, 32'hC1);
    cfg(3'd3, 47);
    check(busy && !s_ready, "R6 immediate block load", {busy, s_ready}, 2'b10);
    send(32'hC0); send(32'hC1);
    wait_end("R6 single block list end");

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule